// File: doc/BRIEF.md
# SPI Register-File Target Port

This block lets an external SPI host read and write a small byte-wide register file that holds timekeeping, alarm, control, status and charger settings. The register storage and its side effects are in other blocks. This block decodes the serial protocol and presents a parallel port: a register index, a one-cycle write strobe with its data, and a combinational read-data input.

The bus runs in SPI mode 3 with an active-high select. The clock idles high. The host changes MOSI after each falling edge and both sides sample on the rising edge. Every transfer opens with a command byte: its top bit requests a write when set and a read when clear, and its low seven bits name the starting register. Each following byte writes to or reads from the current register, and the index then moves up by one, so a burst covers consecutive registers.

All SPI pins pass through two-flop synchronizers into the system clock domain, and the bit and byte state machine runs there. The SPI clock must therefore be several times slower than the system clock.

Top module: `spi_rf_target`

## Requirements
- R1: MOSI is sampled on rising SPI clock edges while select is high. Each byte is 8 bits, most significant bit first, and the first byte of a transfer is the command byte.
- R2: While select is low, SPI clock and MOSI activity is ignored and the bit count is cleared. The next transfer always starts with a fresh command byte, even after a partial byte was aborted.
- R3: In the command byte, bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6:0 are the starting register index. A read never raises the write strobe.
- R4: In a write transfer, each complete data byte raises `regWrEn` for exactly one system clock cycle. During that cycle `regAddr` holds the current index and `regWrData` holds the received byte.
- R5: After each data byte the index increases by one. A burst read starting at index 0x00 returns registers 0x00 to 0x06 in order, and a burst write fills consecutive registers.
- R6: Valid indices are 0x00 to 0x11. A data byte addressed above 0x11 produces no write strobe. A read above 0x11 returns 0x00 whatever `regRdData` shows.
- R7: On a read, MISO carries the addressed register most significant bit first. Each bit is launched after a falling SPI clock edge, and the first bit is valid before the first rising edge after the command byte.
- R8: MISO is high-impedance whenever select is low, including after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| spiSclk | input | 1 | SPI clock, idles high |
| spiCs | input | 1 | Chip select, active high |
| spiMosi | input | 1 | Serial data from host |
| spiMiso | output | 1 | Serial data to host, high-impedance when deselected |
| regAddr | output | 7 | Current register index |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Write data, valid with `regWrEn` |
| regRdData | input | 8 | Read data for the register at `regAddr` |

## Verification
The hardest case is a burst that crosses the last valid index. There the design must stop trusting `regRdData` and return zero on MISO, while the launch timing of the first bit stays intact. The bench register model returns a nonzero filler byte for any index above 0x11, so a missing range check shows up as a wrong byte. A burst read starting at 0x10 carries the index across the edge inside one transfer. A second delicate case is a partial byte abandoned by dropping select. The bench shifts three bits and deselects, then runs a full write and checks that the next strobe lands at the right index with the right data.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  typedef enum logic {
    PH_CMD  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;

  // Strobes from control to datapath, each valid for one system clock cycle
  typedef struct packed {
    logic shiftIn;   // rising SPI edge: take a MOSI bit
    logic cmdDone;   // command byte complete
    logic dataDone;  // data byte complete
    logic txLoad;    // first falling edge after a byte: load read data
    logic txShift;   // other falling edges: move to the next MISO bit
    logic clear;     // select low: return to idle
  } ctrl_strb_t;

endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg[g] <= '0;
      else       stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_rf_ctrl.sv
module spi_rf_ctrl
  import spi_rf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclkS,
  input  logic       csS,
  output ctrl_strb_t strb
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic             sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  phase_e           phase;
  logic             boundary;
  logic             riseEv;
  logic             fallEv;
  logic             byteDone;

  assign riseEv   = csS &&  sclkS && !sclkPrev;
  assign fallEv   = csS && !sclkS &&  sclkPrev;
  assign byteDone = riseEv && (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      bitCnt   <= '0;
      phase    <= PH_CMD;
      boundary <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      if (!csS) begin
        bitCnt   <= '0;
        phase    <= PH_CMD;
        boundary <= 1'b0;
      end else begin
        if (riseEv) bitCnt <= bitCnt + CNT_W'(1);
        if (byteDone) begin
          phase    <= PH_DATA;
          boundary <= 1'b1;
        end else if (fallEv) begin
          boundary <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.shiftIn  = riseEv;
    strb.cmdDone  = byteDone && (phase == PH_CMD);
    strb.dataDone = byteDone && (phase == PH_DATA);
    strb.txLoad   = fallEv && boundary;
    strb.txShift  = fallEv && !boundary;
    strb.clear    = !csS;
  end

  // R2: deselecting always clears the bit position
  p_bitcnt_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csS |=> (bitCnt == '0));

  // R3: once the command byte is taken, the transfer stays in data phase
  p_phase_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (csS && phase == PH_DATA) |=> (phase == PH_DATA));

  // R1: no bit is taken while deselected
  p_no_shift_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !csS |-> !strb.shiftIn);

endmodule

// File: rtl/spi_rf_datapath.sv
module spi_rf_datapath
  import spi_rf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LAST_IDX = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strb_t        strb,
  input  logic              mosiS,
  input  logic [DATA_W-1:0] regRdData,
  output logic [DATA_W-2:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  output logic              txBit
);

  localparam int ADDR_W = DATA_W - 1;
  localparam logic [ADDR_W-1:0] ADDR_MAX = '1;
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(LAST_IDX);

  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxByte;
  logic [ADDR_W-1:0] addr;
  logic              isWrite;
  logic [DATA_W-1:0] txReg;
  logic              inRange;
  logic [DATA_W-1:0] rdVal;

  assign rxByte  = {rxShift[DATA_W-2:0], mosiS};
  assign inRange = (addr <= ADDR_LAST);
  assign rdVal   = inRange ? regRdData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      addr    <= '0;
      isWrite <= 1'b0;
      txReg   <= '0;
    end else if (strb.clear) begin
      rxShift <= '0;
      addr    <= '0;
      isWrite <= 1'b0;
      txReg   <= '0;
    end else begin
      if (strb.shiftIn) rxShift <= rxByte;
      if (strb.cmdDone) begin
        isWrite <= rxByte[DATA_W-1];
        addr    <= rxByte[ADDR_W-1:0];
      end else if (strb.dataDone && addr != ADDR_MAX) begin
        addr <= addr + ADDR_W'(1);
      end
      if (strb.txLoad)       txReg <= rdVal;
      else if (strb.txShift) txReg <= {txReg[DATA_W-2:0], 1'b0};
    end
  end

  assign regWrEn   = strb.dataDone && isWrite && inRange;
  assign regWrData = rxByte;
  assign regAddr   = addr;
  assign txBit     = txReg[DATA_W-1];

  // R4: a write strobe never lasts two cycles
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R5: each data byte moves the index up by one
  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataDone && !strb.cmdDone && addr != ADDR_MAX) |=> (addr == $past(addr) + ADDR_W'(1)));

  // R5: without a byte boundary the index holds
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.dataDone && !strb.cmdDone && !strb.clear) |=> $stable(addr));

  // R7: MISO data moves only on a falling SPI edge
  p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.txLoad && !strb.txShift && !strb.clear) |=> $stable(txReg));

endmodule

// File: rtl/spi_rf_target.sv
module spi_rf_target
  import spi_rf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int LAST_IDX    = 17,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spiSclk,
  input  logic              spiCs,
  input  logic              spiMosi,
  output logic              spiMiso,
  output logic [DATA_W-2:0] regAddr,
  output logic              regWrEn,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);

  logic [2:0] pinsS;
  ctrl_strb_t strb;
  logic       txBit;

  spi_rf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({spiSclk, spiCs, spiMosi}),
    .dout (pinsS)
  );

  spi_rf_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .sclkS (pinsS[2]),
    .csS   (pinsS[1]),
    .strb  (strb)
  );

  spi_rf_datapath #(.DATA_W(DATA_W), .LAST_IDX(LAST_IDX)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .mosiS     (pinsS[0]),
    .regRdData (regRdData),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .txBit     (txBit)
  );

  assign spiMiso = spiCs ? txBit : 1'bz;

  // R6: no strobe leaves the block for an index past the last register
  p_no_wr_out_of_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> (regAddr <= (DATA_W-1)'(LAST_IDX)));

endmodule

// File: tb/tb_spi_rf_target.sv
`timescale 1ns/1ps
module tb_spi_rf_target;

  localparam int CLK_P = 10;
  localparam int HALF  = 80;
  localparam int NREG  = 18;

  typedef struct packed {
    logic [6:0] idx;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h00, 8'h59}, '{7'h02, 8'h23}, '{7'h07, 8'h80},
    '{7'h0F, 8'h04}, '{7'h10, 8'hA3}, '{7'h11, 8'hFF}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       spiSclk = 1'b1;
  logic       spiCs = 1'b0;
  logic       spiMosi = 1'b0;
  wire        spiMiso;
  logic [6:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;

  logic [7:0] regs [NREG];
  int         wrCount = 0;
  logic [6:0] lastWrAddr = '0;
  logic [7:0] lastWrData = '0;
  int         nRun = 0;
  int         nFail = 0;
  bit         finished = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_rf_target dut (
    .clk       (clk),
    .rstN      (rstN),
    .spiSclk   (spiSclk),
    .spiCs     (spiCs),
    .spiMosi   (spiMosi),
    .spiMiso   (spiMiso),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData)
  );

  // Register file model: filler 0xA5 beyond the last index
  assign regRdData = (regAddr < 7'(NREG)) ? regs[regAddr] : 8'hA5;

  initial for (int i = 0; i < NREG; i++) regs[i] = 8'h00;

  always @(negedge clk) begin
    if (regWrEn === 1'b1) begin
      wrCount    <= wrCount + 1;
      lastWrAddr <= regAddr;
      lastWrData <= regWrData;
      if (regAddr < 7'(NREG)) regs[regAddr] <= regWrData;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spiSclk = 1'b0;
      spiMosi = tx[i];
      #HALF;
      rx[i] = spiMiso;
      spiSclk = 1'b1;
      #HALF;
    end
  endtask

  task automatic csOn();
    spiCs = 1'b1;
    #HALF;
  endtask

  task automatic csOff();
    #HALF;
    spiCs = 1'b0;
    #(HALF*2);
  endtask

  task automatic writeBurst(input logic [6:0] idx, input logic [7:0] d [8], input int n);
    logic [7:0] rx;
    csOn();
    xferByte({1'b1, idx}, rx);
    for (int k = 0; k < n; k++) xferByte(d[k], rx);
    csOff();
  endtask

  task automatic readBurst(input logic [6:0] idx, input int n, output logic [7:0] q [8]);
    logic [7:0] rx;
    csOn();
    xferByte({1'b0, idx}, rx);
    for (int k = 0; k < 8; k++) q[k] = 8'h00;
    for (int k = 0; k < n; k++) begin
      xferByte(8'h00, rx);
      q[k] = rx;
    end
    csOff();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] wd [8];
    logic [7:0] rq [8];
    int         cnt0;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk("R4 reset strobe", 32'(regWrEn), 32'd0);
    chk("R8 reset miso z", 32'(spiMiso === 1'bz), 32'd1);
    chk("R5 reset index", 32'(regAddr), 32'd0);

    // Vector table: write each value, read it back
    for (int v = 0; v < 6; v++) begin
      cnt0 = wrCount;
      for (int k = 0; k < 8; k++) wd[k] = 8'h00;
      wd[0] = VECS[v].data;
      writeBurst(VECS[v].idx, wd, 1);
      chk("R4 one strobe per byte", 32'(wrCount - cnt0), 32'd1);
      chk("R3 write index", 32'(lastWrAddr), 32'(VECS[v].idx));
      chk("R1 write data", 32'(lastWrData), 32'(VECS[v].data));
      cnt0 = wrCount;
      readBurst(VECS[v].idx, 1, rq);
      chk("R7 readback", 32'(rq[0]), 32'(VECS[v].data));
      chk("R3 read gives no strobe", 32'(wrCount - cnt0), 32'd0);
    end

    // Burst write of the seven time registers from index 0
    cnt0 = wrCount;
    for (int k = 0; k < 8; k++) wd[k] = 8'h10 + 8'(k * 17);
    writeBurst(7'h00, wd, 7);
    chk("R5 burst write strobes", 32'(wrCount - cnt0), 32'd7);
    for (int k = 0; k < 7; k++) chk("R5 burst write content", 32'(regs[k]), 32'(wd[k]));

    // Burst read of the seven time registers
    readBurst(7'h00, 7, rq);
    for (int k = 0; k < 7; k++) chk("R5 burst read order", 32'(rq[k]), 32'(wd[k]));

    // Out-of-range writes produce no strobe
    cnt0 = wrCount;
    wd[0] = 8'h77;
    writeBurst(7'h12, wd, 1);
    chk("R6 no strobe at 0x12", 32'(wrCount - cnt0), 32'd0);
    writeBurst(7'h7F, wd, 1);
    chk("R6 no strobe at 0x7F", 32'(wrCount - cnt0), 32'd0);

    // Write burst crossing the last index: only 0x11 strobes
    cnt0 = wrCount;
    wd[0] = 8'h5A; wd[1] = 8'h66;
    writeBurst(7'h11, wd, 2);
    chk("R6 crossing write strobes", 32'(wrCount - cnt0), 32'd1);
    chk("R6 crossing write addr", 32'(lastWrAddr), 32'h11);

    // Out-of-range read returns zero despite filler
    readBurst(7'h12, 1, rq);
    chk("R6 read 0x12 is zero", 32'(rq[0]), 32'd0);

    // Read burst crossing the last index
    readBurst(7'h10, 3, rq);
    chk("R5 cross read 0x10", 32'(rq[0]), 32'(regs[16]));
    chk("R5 cross read 0x11", 32'(rq[1]), 32'h5A);
    chk("R6 cross read 0x12", 32'(rq[2]), 32'd0);

    // Aborted partial byte, then a clean write
    spiCs = 1'b1;
    #HALF;
    for (int i = 0; i < 3; i++) begin
      spiSclk = 1'b0; spiMosi = 1'b1; #HALF;
      spiSclk = 1'b1; #HALF;
    end
    csOff();
    cnt0 = wrCount;
    wd[0] = 8'h3C;
    writeBurst(7'h0F, wd, 1);
    chk("R2 after abort strobes", 32'(wrCount - cnt0), 32'd1);
    chk("R2 after abort addr", 32'(lastWrAddr), 32'h0F);
    chk("R2 after abort data", 32'(lastWrData), 32'h3C);

    // Clock activity while deselected is ignored
    cnt0 = wrCount;
    for (int i = 0; i < 24; i++) begin
      spiSclk = 1'b0; spiMosi = 1'(i); #HALF;
      spiSclk = 1'b1; #HALF;
    end
    #(HALF*2);
    chk("R2 idle clocks no strobe", 32'(wrCount - cnt0), 32'd0);
    chk("R8 miso z when deselected", 32'(spiMiso === 1'bz), 32'd1);
    readBurst(7'h0F, 1, rq);
    chk("R2 register untouched", 32'(rq[0]), 32'h3C);
    chk("R8 miso z after read", 32'(spiMiso === 1'bz), 32'd1);

    summary();
    finished = 1;
    $finish;
  end

endmodule